// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

This block holds three independent 32-bit down-counters behind a simple register bus. Each channel counts at a rate derived from a shared peripheral clock enable, divided by a selectable power-of-four prescaler. When a channel's count steps past zero it takes a fresh value from its reload register and raises a sticky underflow flag. An interrupt enable in the same control register gates that flag onto the channel's own interrupt line.

Software sets a channel's interval by writing its counter. It picks periodic operation with a non-zero reload value, or one-shot operation with a zero reload value. A single start register runs and halts the channels. The counters can be read at any time to measure elapsed time.

Top module: `rtim_top`

## Requirements
- R1: After reset every counter and reload register reads 0, every control register reads 0x0020, the start register reads 0 and all interrupt outputs are low.
- R2: The start register is at byte address 0x00. Channel n occupies base 0x08 + 0x0C*n, with its counter at base+0, its reload value at base+4 and its control register at base+8. Reads of any other address return 0. A write to one register leaves all others unchanged.
- R3: Bit n of the start register runs channel n. While the bit is clear the channel's counter holds its value.
- R4: A count step occurs once per 4 << (2*sel) enable pulses while running, where sel is control bits [2:0]. Values 4 to 7 give the ratio 4. The prescaler restarts from zero when a start bit goes from 0 to 1.
- R5: A count step decrements a non-zero counter. A step taken at zero is an underflow: in that same cycle the counter loads the reload value and the flag (control bit 8) sets.
- R6: If the reload value is zero, an underflow leaves the counter at zero and the channel makes no further underflows until its counter or reload register is written or its start bit rises again.
- R7: The flag is sticky. A control write with bit 8 at 0 clears it, and a write with bit 8 at 1 has no effect on it. If a hardware set and a software clear land in the same cycle, the flag ends up set.
- R8: The channel interrupt output is high exactly while both the flag and the interrupt enable (control bit 5) are set.
- R9: A bus write to a counter in the same cycle as a count step stores the written value, and that step is dropped.
- R10: Only control bits [2:0], 5 and 8 hold state. All other control bits, and start register bits 3 and up, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tick_en_i | input | 1 | Peripheral clock enable feeding the prescalers |
| irq_o | output | 3 | Per-channel underflow interrupt |

## Verification
The hardest cases to reach from the ports are the collisions. One is an underflow step arriving in the same cycle as a software flag clear. The other is a count step arriving in the same cycle as a counter write. Both need the prescaler to sit exactly on its terminal enable pulse when the bus write lands. The bench drives the enable one pulse at a time, restarts the prescaler through a start-bit rise and counts pulses up to one short of the ratio. It then issues the write in the cycle that carries the final pulse. Random runs draw prescaler selections, intervals, reload values (zero included) and pulse counts. They compare the counter, flag and interrupt against a closed-form count model.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  localparam int DATA_W    = 32;
  localparam int CTL_W     = 16;
  localparam int PS_W      = 8;
  localparam int SEL_W     = 3;
  localparam int BIT_FLAG  = 8;
  localparam int BIT_IE    = 5;
  localparam int START_W   = 8;
  localparam logic [CTL_W-1:0] CTL_RESET = 16'h0020;

  // terminal prescale count for a selection; out-of-range selections fall back to /4
  function automatic logic [PS_W-1:0] ps_limit(input logic [SEL_W-1:0] sel);
    if (sel < 3'd4) return PS_W'((32'd4 << (2 * sel)) - 32'd1);
    else            return PS_W'(3);
  endfunction
endpackage

// File: rtl/rtim_prescale.sv
module rtim_prescale
  import rtim_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  logic [PS_W-1:0] pc_q;
  logic [PS_W-1:0] limit;

  assign limit  = ps_limit(sel_i);
  // >= keeps the divider from running away when sel shrinks mid-count
  assign step_o = run_i & tick_en_i & (pc_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pc_q <= '0;
    else if (restart_i)          pc_q <= '0;
    else if (run_i && tick_en_i) pc_q <= (pc_q >= limit) ? '0 : pc_q + 1'b1;
  end

  AST_PS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> pc_q == '0); // R4
  AST_PS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pc_q == '0); // R4
endmodule

// File: rtl/rtim_channel.sv
module rtim_channel
  import rtim_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              tick_en_i,
  input  logic              wr_cnt_i,
  input  logic              wr_rld_i,
  input  logic              wr_ctl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  rld_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  logic [SEL_W-1:0] psel_q;
  logic             ie_q, flag_q, parked_q;
  logic             ps_step, step, uflow, sw_clr;

  rtim_prescale u_ps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .restart_i(restart_i),
    .tick_en_i(tick_en_i),
    .sel_i    (psel_q),
    .step_o   (ps_step)
  );

  // a bus write to the counter swallows a coincident step
  assign step   = ps_step & ~parked_q & ~wr_cnt_i;
  assign uflow  = step & (cnt_q == '0);
  assign sw_clr = wr_ctl_i & ~wdata_i[BIT_FLAG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_cnt_i)  cnt_q <= wdata_i[CNT_W-1:0];
      else if (step) cnt_q <= uflow ? rld_q : cnt_q - 1'b1;
      if (wr_rld_i)  rld_q <= wdata_i[CNT_W-1:0];
    end
  end

  // one-shot: a zero reload parks the channel after its underflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  parked_q <= 1'b0;
    else if (wr_cnt_i || wr_rld_i || restart_i)   parked_q <= 1'b0;
    else if (uflow && rld_q == '0)                parked_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psel_q <= CTL_RESET[SEL_W-1:0];
      ie_q   <= CTL_RESET[BIT_IE];
      flag_q <= CTL_RESET[BIT_FLAG];
    end else begin
      if (wr_ctl_i) begin
        psel_q <= wdata_i[SEL_W-1:0];
        ie_q   <= wdata_i[BIT_IE];
      end
      if (uflow)       flag_q <= 1'b1;
      else if (sw_clr) flag_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = {7'b0, flag_q, 2'b0, ie_q, 2'b0, psel_q};
  assign irq_o = flag_q & ie_q;

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !wr_cnt_i |=> $stable(cnt_q)); // R3
  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && cnt_q != '0 |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1)); // R5
  AST_UFLOW_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow |=> cnt_q == $past(rld_q) && flag_q); // R5
  AST_PARKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parked_q && !wr_cnt_i && !wr_rld_i && !restart_i |=> cnt_q == '0 && parked_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !sw_clr |=> flag_q); // R7
  AST_CNT_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_q == $past(wdata_i[CNT_W-1:0])); // R9
endmodule

// File: rtl/rtim_top.sv
module rtim_top
  import rtim_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int START_ADR = 'h00,
  parameter int CH_BASE   = 'h08,
  parameter int CH_STRIDE = 'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              tick_en_i,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int OFF_CNT = 0;
  localparam int OFF_RLD = 4;
  localparam int OFF_CTL = 8;

  function automatic logic [ADDR_W-1:0] reg_adr(input int ch, input int off);
    return ADDR_W'(CH_BASE + CH_STRIDE * ch + off);
  endfunction

  logic [NUM_CH-1:0] start_q, start_rise;
  logic              wr, wr_start;
  logic [CNT_W-1:0]  cnt_a [NUM_CH];
  logic [CNT_W-1:0]  rld_a [NUM_CH];
  logic [CTL_W-1:0]  ctl_a [NUM_CH];

  assign wr         = req_i & we_i;
  assign wr_start   = wr & (addr_i == ADDR_W'(START_ADR));
  assign start_rise = wr_start ? (wdata_i[NUM_CH-1:0] & ~start_q) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_q <= '0;
    else if (wr_start) start_q <= wdata_i[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    rtim_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (start_q[g]),
      .restart_i(start_rise[g]),
      .tick_en_i(tick_en_i),
      .wr_cnt_i (wr & (addr_i == reg_adr(g, OFF_CNT))),
      .wr_rld_i (wr & (addr_i == reg_adr(g, OFF_RLD))),
      .wr_ctl_i (wr & (addr_i == reg_adr(g, OFF_CTL))),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_a[g]),
      .rld_o    (rld_a[g]),
      .ctl_o    (ctl_a[g]),
      .irq_o    (irq_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(START_ADR)) rdata_o = 32'(start_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == reg_adr(i, OFF_CNT)) rdata_o = 32'(cnt_a[i]);
      if (addr_i == reg_adr(i, OFF_RLD)) rdata_o = 32'(rld_a[i]);
      if (addr_i == reg_adr(i, OFF_CTL)) rdata_o = 32'(ctl_a[i]);
    end
  end

  AST_START_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_start |=> $stable(start_q)); // R3
endmodule

// File: tb/sim_rtim_top.sv
`timescale 1ns/1ps
module sim_rtim_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtim_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_en_i(tick), .irq_o(irq)
  );

  function automatic logic [7:0] a_cnt(int ch); return 8'(8'h08 + 8'h0C * ch);     endfunction
  function automatic logic [7:0] a_rld(int ch); return 8'(8'h08 + 8'h0C * ch + 4); endfunction
  function automatic logic [7:0] a_ctl(int ch); return 8'(8'h08 + 8'h0C * ch + 8); endfunction
  function automatic int ratio(int sel); return (sel < 4) ? (4 << (2 * sel)) : 4; endfunction
  function automatic longint exp_cnt(longint c, longint l, longint steps);
    if (steps <= c) return c - steps;
    return l - ((steps - (c + 1)) % (l + 1));
  endfunction

  task automatic check(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req_tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; tick = tk;
    @(negedge clk); req = 0; we = 0; tick = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; req = 1; we = 0;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int ch = 0; ch < 3; ch++) begin
      rd(a_cnt(ch), d); check("R1 cnt", d, 0);
      rd(a_rld(ch), d); check("R1 rld", d, 0);
      rd(a_ctl(ch), d); check("R1 ctl", d, 32'h20);
    end
    rd(8'h00, d); check("R1 start", d, 0);
    check("R1 irq", 32'(irq), 0);

    // R2 map, R10 writable bits
    for (int ch = 0; ch < 3; ch++) begin
      wr(a_cnt(ch), 32'h1000_0000 | (ch * 32'h111));
      wr(a_rld(ch), 32'hA5A5_0000 + ch);
    end
    for (int ch = 0; ch < 3; ch++) begin
      rd(a_cnt(ch), d); check("R2 cnt", d, 32'h1000_0000 | (ch * 32'h111));
      rd(a_rld(ch), d); check("R2 rld", d, 32'hA5A5_0000 + ch);
    end
    rd(8'h04, d); check("R2 unmapped", d, 0);
    rd(8'h2C, d); check("R2 unmapped", d, 0);
    wr(a_ctl(1), 32'hFFFF); rd(a_ctl(1), d); check("R10 ctl bits", d, 32'h27);
    rd(a_ctl(0), d); check("R2 ctl other", d, 32'h20);
    wr(8'h00, 32'hFF); rd(8'h00, d); check("R10 start bits", d, 32'h07);
    wr(8'h00, 0);
    wr(a_ctl(1), 32'h20);

    // R3 halt, R4 restart
    wr(a_cnt(1), 100); wr(8'h00, 32'h2);
    ticks(8); rd(a_cnt(1), d); check("R4 sel0 steps", d, 98);
    wr(8'h00, 0); ticks(20); rd(a_cnt(1), d); check("R3 halted hold", d, 98);
    wr(8'h00, 32'h2); ticks(3); wr(8'h00, 0);
    wr(8'h00, 32'h2); ticks(3); rd(a_cnt(1), d); check("R4 restart", d, 98);
    ticks(1); rd(a_cnt(1), d); check("R4 restart step", d, 97);

    // R4 out-of-range select and sel 1
    wr(a_ctl(2), 32'h27); wr(a_cnt(2), 10); wr(8'h00, 32'h4);
    ticks(8); rd(a_cnt(2), d); check("R4 sel7 as /4", d, 8);
    rd(a_cnt(1), d); check("R3 stopped ch1", d, 97);
    wr(a_ctl(2), 32'h21); ticks(16); rd(a_cnt(2), d); check("R4 sel1 /16", d, 7);
    wr(8'h00, 0);

    // R5 underflow, R7 sticky, R8 irq
    wr(a_ctl(0), 32'h20); wr(a_cnt(0), 0); wr(a_rld(0), 5); wr(8'h00, 32'h1);
    ticks(4);
    rd(a_cnt(0), d); check("R5 reload", d, 5);
    rd(a_ctl(0), d); check("R5 flag set", d, 32'h120);
    check("R8 irq on", 32'(irq), 32'h1);
    wr(a_ctl(0), 32'h100); rd(a_ctl(0), d); check("R7 write1 keeps", d, 32'h100);
    check("R8 irq masked", 32'(irq), 0);
    wr(a_ctl(0), 32'h120); check("R8 irq unmasked", 32'(irq), 32'h1);
    wr(a_ctl(0), 32'h20); rd(a_ctl(0), d); check("R7 clear", d, 32'h20);
    check("R8 irq cleared", 32'(irq), 0);

    // R7 set beats clear in the same cycle
    wr(a_cnt(0), 0); ticks(3); wr(a_ctl(0), 32'h20, 1'b1);
    rd(a_ctl(0), d); check("R7 set wins", d, 32'h120);
    rd(a_cnt(0), d); check("R5 reload collide", d, 5);

    // R9 counter write beats step
    wr(a_cnt(0), 10); ticks(3); wr(a_cnt(0), 50, 1'b1);
    rd(a_cnt(0), d); check("R9 write wins", d, 50);
    ticks(4); rd(a_cnt(0), d); check("R9 next step", d, 49);

    // R6 one-shot
    wr(a_ctl(0), 32'h20); wr(a_rld(0), 0); wr(a_cnt(0), 2);
    ticks(12);
    rd(a_cnt(0), d); check("R6 at zero", d, 0);
    rd(a_ctl(0), d); check("R6 single flag", d, 32'h120);
    wr(a_ctl(0), 32'h20); ticks(40);
    rd(a_ctl(0), d); check("R6 no repeat flag", d, 32'h20);
    rd(a_cnt(0), d); check("R6 parked cnt", d, 0);
    check("R6 irq quiet", 32'(irq), 0);
    wr(a_rld(0), 3); ticks(4);
    rd(a_cnt(0), d); check("R6 rearm reload", d, 3);
    rd(a_ctl(0), d); check("R6 rearm flag", d, 32'h120);
    wr(8'h00, 0);

    // random intervals, R4 R5 R6 R8
    for (int it = 0; it < 24; it++) begin
      int ch, sel, c, l, n;
      longint steps;
      logic flag;
      ch  = int'($urandom_range(0, 2));
      sel = int'($urandom_range(0, 7));
      c   = int'($urandom_range(0, 40));
      l   = int'($urandom_range(0, 20));
      n   = int'($urandom_range(0, 700));
      wr(8'h00, 0);
      wr(a_ctl(ch), 32'h20 | 32'(sel));
      wr(a_cnt(ch), 32'(c)); wr(a_rld(ch), 32'(l));
      wr(8'h00, 32'(1 << ch));
      ticks(n);
      steps = longint'(n / ratio(sel));
      flag  = (steps >= c + 1);
      rd(a_cnt(ch), d); check("R5 random cnt", d, 32'(exp_cnt(c, l, steps)));
      rd(a_ctl(ch), d); check("R4 random ctl", d, 32'h20 | 32'(sel) | (flag ? 32'h100 : 0));
      check("R8 random irq", 32'(irq[ch]), 32'(flag));
      wr(a_ctl(ch), 32'h20);
    end
    wr(8'h00, 0);
    finish_run();
  end
endmodule